// File: doc/BRIEF.md
# Interrupt Latch, Mask and Read-to-Clear Bank

This block holds the interrupt state of a two-wire serial bus master. Twelve event sources from the bus engine feed a raw status word. Ten of these sources are edge events. Each edge event sets a sticky bit that stays set until software reads a clear location. The other two sources, receive-threshold-reached and transmit-threshold-reached, are level conditions. They follow the FIFO state and reading a clear location does not change them. A software mask selects which raw bits reach a masked status word. The registered OR of the masked status word drives a single interrupt line.

Every edge source has its own read-to-clear location. A read of that location returns the bit's value before the clear and then clears that bit alone. One further location clears every edge source at once. When a transfer aborts, the bank also records the cause bits in an abort-cause register. That register is wiped when the abort interrupt is cleared, so software must read the cause before it acknowledges the abort.

The register port is a word-indexed read/write strobe interface. Read data is combinational in the same cycle as `rd_en`. Clearing happens at the clock edge that ends the read.

Top module: `intr_regbank`

## Requirements
- R1: After reset the raw status, mask, masked status and abort-cause registers all read 0, and `irq` is 0.
- R2: A pulse on `evt_pulse[i]` for an edge source (every bit except 2 and 4) sets raw status bit i at the next clock edge. The bit then stays set while its pulse is low.
- R3: The dedicated clear locations sit at word indices 4 to 13. They are assigned in ascending source-bit order, skipping bits 2 and 4: bit 0 maps to 4, 1 to 5, 3 to 6, 5 to 7, 6 to 8, and 7 to 11 map to 9 to 13. A read of one of these locations clears only its own raw bit.
- R4: A read of word index 3 clears every edge raw bit and the abort-cause register.
- R5: Raw bit 2 follows `lvl_rx_full` and raw bit 4 follows `lvl_tx_empty`, each with one cycle of delay. Clear reads and `evt_pulse[2]`/`evt_pulse[4]` have no effect on these two bits.
- R6: Word index 0 is the mask register, which is writable and reads back what was written. Word index 1 reads raw status ANDed with the mask. Word index 2 reads raw status.
- R7: `irq` is registered. In each cycle it equals the OR of the masked status word of the previous cycle.
- R8: When an edge event arrives in the same cycle as a read that clears its bit, the bit remains set.
- R9: An event on raw bit 6 (abort) ORs `abrt_cause`, limited to the defined cause bits 0–5, 7 and 9–12, into the abort-cause register at word index 14. Bits 6 and 8 of that register always read 0.
- R10: A read of the abort clear location (word index 8) also clears the abort-cause register. If an abort event arrives in the same cycle, the register keeps that event's cause bits.
- R11: A read of a dedicated clear location returns the bit's value before the clear in data bit 0. A read of word index 3 returns 1 in bit 0 when any edge bit was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | NSRC | One-cycle event pulses from the bus engine, one per source bit |
| lvl_rx_full | input | 1 | Receive threshold level condition (raw bit 2) |
| lvl_tx_empty | input | 1 | Transmit threshold level condition (raw bit 4) |
| abrt_cause | input | ABW | Abort cause bits, sampled with an abort event |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Word index of the register accessed |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid in the cycle of `rd_en` |
| irq | output | 1 | Registered interrupt request |

## Verification
The two functions that can collide are event latching and the read side effect. A new event or abort cause can arrive in the same cycle as a read that clears the same bit. The bench provokes this by driving the pulse and the clear read in one cycle, both through a dedicated location and through the combined one. It then reads back raw status and the abort-cause register and expects the bit and the new cause to have survived. Other bits set alongside the collision are checked to confirm they were cleared as normal.

// File: rtl/intr_pkg.sv
package intr_pkg;
   localparam int NSRC_DEF  = 12;
   localparam int ABW_DEF   = 13;
   localparam int RXF_BIT   = 2;
   localparam int TXE_BIT   = 4;
   localparam int ABRT_BIT  = 6;
   localparam logic [31:0] LEVEL_SRC = (32'd1 << RXF_BIT) | (32'd1 << TXE_BIT);
   localparam logic [31:0] DEFAULT_EN = 32'h0000_0254;
   localparam logic [31:0] ABRT_VALID = 32'h0000_1EBF;

   localparam int IDX_MASK   = 0;
   localparam int IDX_MSTAT  = 1;
   localparam int IDX_RAW    = 2;
   localparam int IDX_CLRALL = 3;
   localparam int IDX_CLR0   = 4;
   localparam int IDX_ABRT   = 14;

   function automatic int clr_slot(input int src, input logic [31:0] lvl);
      int n;
      n = 0;
      for (int k = 0; k < src; k++)
         if (!lvl[k]) n++;
      return n;
   endfunction

   function automatic int edge_count(input int nsrc, input logic [31:0] lvl);
      int n;
      n = 0;
      for (int k = 0; k < nsrc; k++)
         if (!lvl[k]) n++;
      return n;
   endfunction
endpackage

// File: rtl/intr_src_bit.sv
module intr_src_bit #(
   parameter bit IS_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   input  logic clr,
   output logic q
);
   generate
      if (IS_LEVEL) begin : g_level
         logic unused_clr;
         assign unused_clr = clr;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= d;
         end
      end else begin : g_sticky
         always_ff @(posedge clk) begin
            if (rst)    q <= 1'b0;
            else if (d) q <= 1'b1;
            else if (clr) q <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/intr_abort_cap.sv
module intr_abort_cap #(
   parameter int          ABW   = 13,
   parameter logic [31:0] VALID = 32'h0000_1EBF
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           capture,
   input  logic [ABW-1:0] cause,
   input  logic           clr,
   output logic [ABW-1:0] src
);
   localparam logic [ABW-1:0] KEEP = VALID[ABW-1:0];

   logic [ABW-1:0] cause_ok;
   assign cause_ok = cause & KEEP;

   always_ff @(posedge clk) begin
      if (rst)
         src <= '0;
      else if (capture)
         src <= clr ? cause_ok : (src | cause_ok);
      else if (clr)
         src <= '0;
   end
endmodule

// File: rtl/intr_rd_decode.sv
module intr_rd_decode
   import intr_pkg::*;
#(
   parameter int          NSRC  = 12,
   parameter int          ABW   = 13,
   parameter int          AW    = 4,
   parameter int          DW    = 16,
   parameter logic [31:0] LVL   = 32'h14,
   parameter int          TXA   = 6
) (
   input  logic            rd_en,
   input  logic            wr_en,
   input  logic [AW-1:0]   addr,
   input  logic [NSRC-1:0] raw,
   input  logic [NSRC-1:0] mask,
   input  logic [ABW-1:0]  abrt,
   output logic [DW-1:0]   rdata,
   output logic [NSRC-1:0] clr_vec,
   output logic            clr_abrt,
   output logic            mask_we
);
   localparam logic [NSRC-1:0] LVLM = LVL[NSRC-1:0];
   localparam logic [NSRC-1:0] EDGEM = ~LVLM;

   assign mask_we  = wr_en && (addr == AW'(IDX_MASK));
   assign clr_abrt = clr_vec[TXA];

   always_comb begin
      rdata   = '0;
      clr_vec = '0;
      if (addr == AW'(IDX_MASK))
         rdata[NSRC-1:0] = mask;
      else if (addr == AW'(IDX_MSTAT))
         rdata[NSRC-1:0] = raw & mask;
      else if (addr == AW'(IDX_RAW))
         rdata[NSRC-1:0] = raw;
      else if (addr == AW'(IDX_ABRT))
         rdata[ABW-1:0] = abrt;
      else if (addr == AW'(IDX_CLRALL)) begin
         rdata[0] = |(raw & EDGEM);
         clr_vec  = rd_en ? EDGEM : '0;
      end else begin
         for (int i = 0; i < NSRC; i++) begin
            if (!LVLM[i] && addr == AW'(IDX_CLR0 + clr_slot(i, LVL))) begin
               rdata[0]   = raw[i];
               clr_vec[i] = rd_en;
            end
         end
      end
      if (!rd_en) rdata = '0;
   end
endmodule

// File: rtl/intr_regbank.sv
module intr_regbank
   import intr_pkg::*;
#(
   parameter int          NSRC     = NSRC_DEF,
   parameter int          ABW      = ABW_DEF,
   parameter int          AW       = 4,
   parameter int          DW       = 16,
   parameter logic [31:0] MASK_RST = 32'h0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] evt_pulse,
   input  logic            lvl_rx_full,
   input  logic            lvl_tx_empty,
   input  logic [ABW-1:0]  abrt_cause,
   input  logic            rd_en,
   input  logic            wr_en,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   output logic            irq
);
   localparam logic [NSRC-1:0] LVLM   = LEVEL_SRC[NSRC-1:0];
   localparam int              NEDGE  = edge_count(NSRC, LEVEL_SRC);
   localparam int              NREGS  = IDX_ABRT + 1;

   generate
      if (DW < ABW || DW < NSRC) begin : g_bad_dw
         $error("intr_regbank: DW too narrow for status or abort word");
      end
      if ((1 << AW) < NREGS) begin : g_bad_aw
         $error("intr_regbank: AW cannot reach every register");
      end
      if (IDX_CLR0 + NEDGE > IDX_ABRT) begin : g_bad_map
         $error("intr_regbank: clear locations overlap abort register");
      end
      if (NSRC <= TXE_BIT || NSRC <= ABRT_BIT) begin : g_bad_nsrc
         $error("intr_regbank: NSRC must cover the fixed source bits");
      end
   endgenerate

   logic [NSRC-1:0] raw_q;
   logic [NSRC-1:0] mask_q;
   logic [ABW-1:0]  abrt_q;
   logic [NSRC-1:0] clr_vec;
   logic [NSRC-1:0] lvl_vec;
   logic            clr_abrt;
   logic            mask_we;
   logic            irq_q;

   always_comb begin
      lvl_vec          = '0;
      lvl_vec[RXF_BIT] = lvl_rx_full;
      lvl_vec[TXE_BIT] = lvl_tx_empty;
   end

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         if (LVLM[i]) begin : g_lvl
            intr_src_bit #(.IS_LEVEL(1'b1)) u_bit (
               .clk(clk), .rst(rst), .d(lvl_vec[i]), .clr(clr_vec[i]), .q(raw_q[i])
            );
         end else begin : g_edge
            intr_src_bit #(.IS_LEVEL(1'b0)) u_bit (
               .clk(clk), .rst(rst), .d(evt_pulse[i]), .clr(clr_vec[i]), .q(raw_q[i])
            );
         end
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{evt_pulse & LVLM, lvl_vec & ~LVLM, wdata[DW-1:NSRC]};

   intr_abort_cap #(.ABW(ABW), .VALID(ABRT_VALID)) u_abrt (
      .clk(clk), .rst(rst), .capture(evt_pulse[ABRT_BIT]),
      .cause(abrt_cause), .clr(clr_abrt), .src(abrt_q)
   );

   intr_rd_decode #(
      .NSRC(NSRC), .ABW(ABW), .AW(AW), .DW(DW), .LVL(LEVEL_SRC), .TXA(ABRT_BIT)
   ) u_dec (
      .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .raw(raw_q), .mask(mask_q),
      .abrt(abrt_q), .rdata(rdata), .clr_vec(clr_vec), .clr_abrt(clr_abrt),
      .mask_we(mask_we)
   );

   always_ff @(posedge clk) begin
      if (rst)          mask_q <= MASK_RST[NSRC-1:0];
      else if (mask_we) mask_q <= wdata[NSRC-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) irq_q <= 1'b0;
      else     irq_q <= |(raw_q & mask_q);
   end

   assign irq = irq_q;
endmodule

// File: rtl/intr_regbank_chk.sv
module intr_regbank_chk
   import intr_pkg::*;
#(
   parameter int NSRC = 12,
   parameter int ABW  = 13,
   parameter int AW   = 4,
   parameter int DW   = 16
) (
   input logic            clk,
   input logic            rst,
   input logic [NSRC-1:0] evt_pulse,
   input logic            lvl_rx_full,
   input logic            lvl_tx_empty,
   input logic            rd_en,
   input logic [AW-1:0]   addr,
   input logic [DW-1:0]   rdata,
   input logic            irq,
   input logic [NSRC-1:0] raw,
   input logic [NSRC-1:0] mask,
   input logic [ABW-1:0]  abrt
);
   localparam logic [NSRC-1:0] EDGEM = ~LEVEL_SRC[NSRC-1:0];
   localparam logic [ABW-1:0]  RSVD  = ~ABRT_VALID[ABW-1:0];

   a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (irq == $past(|(raw & mask))));

   a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ((raw & $past(evt_pulse & EDGEM)) == $past(evt_pulse & EDGEM)));

   a_r5_rx_level: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (raw[RXF_BIT] == $past(lvl_rx_full)));

   a_r5_tx_level: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (raw[TXE_BIT] == $past(lvl_tx_empty)));

   a_r6_masked_read: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr == AW'(IDX_MSTAT)) |-> (rdata[NSRC-1:0] == (raw & mask)));

   a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      (abrt & RSVD) == '0);

   a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
      (!rd_en && (raw & EDGEM) != '0) |=> ((raw & $past(raw & EDGEM)) == $past(raw & EDGEM)));
endmodule

bind intr_regbank intr_regbank_chk #(.NSRC(NSRC), .ABW(ABW), .AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .lvl_rx_full(lvl_rx_full),
   .lvl_tx_empty(lvl_tx_empty), .rd_en(rd_en), .addr(addr), .rdata(rdata),
   .irq(irq), .raw(raw_q), .mask(mask_q), .abrt(abrt_q)
);

// File: tb/sim_intr_regbank.sv
`timescale 1ns/1ps
module sim_intr_regbank;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] evt_pulse = '0;
   logic        lvl_rx_full = 1'b0;
   logic        lvl_tx_empty = 1'b0;
   logic [12:0] abrt_cause = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [11:0] EDGE = 12'hFEB;
   localparam logic [12:0] AVAL = 13'h1EBF;

   always #2 clk = ~clk;

   intr_regbank u0 (
      .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .lvl_rx_full(lvl_rx_full),
      .lvl_tx_empty(lvl_tx_empty), .abrt_cause(abrt_cause), .rd_en(rd_en),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk); #1 rd_en = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] ev, input logic [12:0] cause);
      @(negedge clk);
      evt_pulse = ev; abrt_cause = cause;
      @(posedge clk); #1 evt_pulse = '0; abrt_cause = '0;
   endtask

   // event and read in the same cycle
   task automatic coll(input logic [11:0] ev, input logic [12:0] cause,
                       input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      evt_pulse = ev; abrt_cause = cause; rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk); #1 evt_pulse = '0; abrt_cause = '0; rd_en = 1'b0;
   endtask

   function automatic int slot_of(input int src);
      int n;
      n = 0;
      for (int k = 0; k < src; k++)
         if (k != 2 && k != 4) n++;
      return n;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic [11:0] exp_raw;
      logic [12:0] exp_ab;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R1 reset state
      rd(4'd2, d);  chk("R1 raw", d, 16'h0);
      rd(4'd0, d);  chk("R1 mask", d, 16'h0);
      rd(4'd1, d);  chk("R1 masked", d, 16'h0);
      rd(4'd14, d); chk("R1 abort", d, 16'h0);
      chk("R1 irq", {15'h0, irq}, 16'h0);

      // R2, R3, R11: each edge source alone
      for (int i = 0; i < 12; i++) begin
         if (i == 2 || i == 4) continue;
         pulse(12'(1 << i), '0);
         repeat (2) @(posedge clk);
         #1;
         rd(4'd2, d);  chk("R2 latch", d, 16'(1 << i));
         rd(4'(4 + slot_of(i)), d); chk("R11 preclear", d, 16'h1);
         rd(4'd2, d);  chk("R3 cleared", d, 16'h0);
         rd(4'(4 + slot_of(i)), d); chk("R11 second read", d, 16'h0);
      end
      rd(4'd3, d); // also wipes abort register touched by bit 6 test

      // R3: clear each slot with all edge bits set
      for (int i = 0; i < 12; i++) begin
         if (i == 2 || i == 4) continue;
         pulse(EDGE, '0);
         rd(4'(4 + slot_of(i)), d);
         rd(4'd2, d); chk("R3 only own bit", d, 16'(EDGE & ~(12'(1 << i))));
         rd(4'd3, d); chk("R11 combined preclear", d, 16'h1);
         rd(4'd2, d); chk("R4 all cleared", d, 16'h0);
      end
      rd(4'd3, d); chk("R11 combined empty", d, 16'h0);

      // R5 level sources
      @(negedge clk); lvl_rx_full = 1'b1;
      @(posedge clk); #1;
      rd(4'd2, d); chk("R5 rx level set", d, 16'h004);
      rd(4'd3, d);
      rd(4'd2, d); chk("R5 clear no effect", d, 16'h004);
      @(negedge clk); lvl_rx_full = 1'b0; lvl_tx_empty = 1'b1;
      @(posedge clk); #1;
      rd(4'd2, d); chk("R5 follows levels", d, 16'h010);
      @(negedge clk); lvl_tx_empty = 1'b0;
      @(posedge clk); #1;
      pulse(12'h014, '0);
      rd(4'd2, d); chk("R5 pulse ignored", d, 16'h000);

      // R6, R7 mask sweep
      for (int p = 0; p < 6; p++) begin
         logic [11:0] m;
         case (p)
            0: m = 12'h254;
            1: m = 12'h000;
            2: m = 12'hFFF;
            3: m = 12'h0A1;
            4: m = 12'h800;
            default: m = 12'h402;
         endcase
         exp_raw = 12'h883;
         pulse(exp_raw, '0);
         wr(4'd0, {4'h0, m});
         rd(4'd0, d); chk("R6 mask readback", d, {4'h0, m});
         rd(4'd1, d); chk("R6 masked", d, {4'h0, exp_raw & m});
         chk("R7 irq", {15'h0, irq}, {15'h0, |(exp_raw & m)});
         rd(4'd3, d);
         @(posedge clk); #1;
         chk("R7 irq drops", {15'h0, irq}, 16'h0);
      end
      wr(4'd0, 16'h0);

      // R8 collisions
      pulse(12'h009, '0);
      coll(12'h008, '0, 4'd6, d);
      rd(4'd2, d); chk("R8 dedicated collision", d, 16'h009);
      coll(12'h200, '0, 4'd3, d);
      rd(4'd2, d); chk("R8 combined collision", d, 16'h200);
      rd(4'd3, d);

      // R9 abort capture
      pulse(12'h040, 13'h1FFF);
      rd(4'd14, d); chk("R9 valid bits only", d, {3'h0, AVAL});
      rd(4'd8, d);
      rd(4'd14, d); chk("R10 cleared", d, 16'h0);
      rd(4'd2, d);  chk("R10 raw bit cleared", d, 16'h0);
      exp_ab = 13'h0001;
      pulse(12'h040, exp_ab);
      pulse(12'h040, 13'h1000);
      exp_ab = exp_ab | 13'h1000;
      rd(4'd14, d); chk("R9 accumulate", d, {3'h0, exp_ab});
      coll(12'h040, 13'h0008, 4'd8, d);
      rd(4'd14, d); chk("R10 new cause kept", d, 16'h0008);
      rd(4'd2, d);  chk("R8 abort bit kept", d, 16'h040);
      rd(4'd6, d);
      rd(4'd14, d); chk("R3 other clear keeps abort", d, 16'h0008);
      rd(4'd3, d);
      rd(4'd14, d); chk("R4 combined clears abort", d, 16'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule